// File: doc/BRIEF.md
# Neighbor-Walking Graph Convolution Engine

This block evaluates one graph-convolution layer by walking the graph explicitly, one node at a time. For each node it reads two consecutive entries of an offset table to find where that node's neighbor list starts and ends. It reads the node's own embedding. It then steps through the neighbor list. For each neighbor index it fetches that neighbor's embedding, passes every element through a message transform, and folds the result straight into a running aggregate, so no neighbor embedding is ever held. After the last neighbor, the aggregate is combined with the node's own embedding. The sum goes through an update transform and is written to an output embedding memory at the node's index.

The engine is started with a single-cycle `start` pulse. It is told how many nodes and edges the graph holds, and it raises `done` for one cycle when the whole layer has been written. All three source memories are external and synchronous: data answers the cycle after the read enable. Every embedding is a vector of `LANES` signed 16-bit elements with 10 fractional bits. Element i sits in bits [16i+15:16i] of a memory word. Both transforms are per-element affine steps whose scale and bias are parameters.

Top module: `mpn_node_engine`

## Requirements
- R1: Nodes are finished in ascending index order 0 .. num_nodes-1. Each node produces exactly one write with `out_we` high for a single cycle at `out_addr` equal to its index, and all phases of a node finish before the next node starts.
- R2: A node n has the neighbor range [off[n], off[n+1]). The last node uses the captured `num_edges` as its end. An end that is not greater than the start means the node has no neighbors.
- R3: Each position e in a node's range is read from the neighbor table, and the embedding memory is then read at the index that the neighbor table returned.
- R4: The message transform maps each element x to sat(floor(x*1536/1024) + 64). sat clamps the result to [-32768, 32767].
- R5: Messages are merged as they arrive into a per-element running saturating sum whose starting value is 0.
- R6: The written word, element by element, is sat(floor(c*512/1024) - 32), where c = sat(aggregate + own element).
- R7: A node with no neighbors still gets a write, computed from an aggregate equal to the starting value 0.
- R8: The graph size is captured at `start`. A `start` pulse while a layer is in progress is ignored and causes no extra writes and no extra `done`.
- R9: `done` is high for exactly one cycle, in the cycle after the last write. With num_nodes = 0, `done` comes in the cycle after `start` and no write occurs.
- R10: While in reset and directly after it, `done`, `out_we` and all three read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a layer (pulse) |
| num_nodes | input | NODE_W | Nodes in the graph, captured at start |
| num_edges | input | EDGE_W | Total neighbor-table entries, captured at start |
| off_rd_en | output | 1 | Offset table read enable |
| off_addr | output | NODE_W | Offset table address |
| off_data | input | EDGE_W | Offset table data, one cycle after enable |
| nbr_rd_en | output | 1 | Neighbor table read enable |
| nbr_addr | output | EDGE_W | Neighbor table address |
| nbr_data | input | NODE_W | Neighbor index, one cycle after enable |
| emb_rd_en | output | 1 | Input embedding read enable |
| emb_addr | output | NODE_W | Input embedding address |
| emb_data | input | 16*LANES | Input embedding vector, one cycle after enable |
| out_we | output | 1 | Output embedding write enable |
| out_addr | output | NODE_W | Output embedding address |
| out_data | output | 16*LANES | Output embedding vector |
| done | output | 1 | Layer complete (one-cycle pulse) |

## Verification
The embedded properties check on every cycle that writes never come back to back, that writes stay below the captured node count, that `done` is a single-cycle pulse which follows a write whenever the graph is non-empty, and that each embedding fetch uses the index the neighbor table just returned. Whether the written values are arithmetically right only shows in the scenarios. These include mixed degrees with empty neighbor lists, a last node bounded by the edge count, saturating accumulation with large positive and negative inputs, an empty graph, and a second `start` together with a changed node count during a run. Each of these is compared write by write against the bench's behavioural model.

// File: rtl/mpn_pkg.sv
package mpn_pkg;

    localparam int ELEM_W = 16;
    localparam int FRAC_W = 10;

    typedef logic signed [ELEM_W-1:0] elem_t;

    localparam elem_t ELEM_MAX = 16'sh7fff;
    localparam elem_t ELEM_MIN = 16'sh8000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFF_RD,
        ST_OFF_BEG,
        ST_OFF_END,
        ST_SELF,
        ST_NBR,
        ST_GATHER,
        ST_FINAL,
        ST_DONE
    } eng_state_e;

    // Clamp a wide signed value into one embedding element.
    function automatic elem_t clamp_elem(input logic signed [32:0] v);
        if (v > 33'sd32767)       return ELEM_MAX;
        else if (v < -33'sd32768) return ELEM_MIN;
        else                      return v[ELEM_W-1:0];
    endfunction

    // Fixed-point affine step: floor(x*scale / 2^FRAC) + bias, saturated.
    function automatic elem_t affine_step(input elem_t x, input elem_t scale, input elem_t bias);
        logic signed [31:0] prod;
        logic signed [32:0] tot;
        prod = 32'(x) * 32'(scale);
        tot  = 33'(prod >>> FRAC_W) + 33'(bias);
        return clamp_elem(tot);
    endfunction

    function automatic elem_t sat_add(input elem_t a, input elem_t b);
        logic signed [32:0] tot;
        tot = 33'(a) + 33'(b);
        return clamp_elem(tot);
    endfunction

    function automatic elem_t elem_max(input elem_t a, input elem_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mpn_affine.sv
module mpn_affine
    import mpn_pkg::*;
#(
    parameter int    LANES = 4,
    parameter elem_t SCALE = 16'sd1024,
    parameter elem_t BIAS  = 16'sd0,
    localparam int   VEC_W = LANES * ELEM_W
) (
    input  logic [VEC_W-1:0] vec_i,
    output logic [VEC_W-1:0] vec_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            vec_o[l*ELEM_W +: ELEM_W] = affine_step(vec_i[l*ELEM_W +: ELEM_W], SCALE, BIAS);
        end
    end

endmodule

// File: rtl/mpn_aggregate.sv
module mpn_aggregate
    import mpn_pkg::*;
#(
    parameter int LANES   = 4,
    parameter bit USE_MAX = 1'b0,
    localparam int VEC_W  = LANES * ELEM_W
) (
    input  logic [VEC_W-1:0] acc_i,
    input  logic [VEC_W-1:0] val_i,
    output logic [VEC_W-1:0] acc_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (USE_MAX) begin : g_max
            always_comb begin
                acc_o[l*ELEM_W +: ELEM_W] = elem_max(acc_i[l*ELEM_W +: ELEM_W], val_i[l*ELEM_W +: ELEM_W]);
            end
        end else begin : g_sum
            always_comb begin
                acc_o[l*ELEM_W +: ELEM_W] = sat_add(acc_i[l*ELEM_W +: ELEM_W], val_i[l*ELEM_W +: ELEM_W]);
            end
        end
    end

endmodule

// File: rtl/mpn_node_engine.sv
module mpn_node_engine
    import mpn_pkg::*;
#(
    parameter int    LANES     = 4,
    parameter int    NODE_W    = 8,
    parameter int    EDGE_W    = 10,
    parameter bit    AGG_MAX   = 1'b0,
    parameter elem_t MSG_SCALE = 16'sd1536,
    parameter elem_t MSG_BIAS  = 16'sd64,
    parameter elem_t UPD_SCALE = 16'sd512,
    parameter elem_t UPD_BIAS  = -16'sd32,
    localparam int   VEC_W     = LANES * ELEM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NODE_W-1:0] num_nodes,
    input  logic [EDGE_W-1:0] num_edges,
    output logic              off_rd_en,
    output logic [NODE_W-1:0] off_addr,
    input  logic [EDGE_W-1:0] off_data,
    output logic              nbr_rd_en,
    output logic [EDGE_W-1:0] nbr_addr,
    input  logic [NODE_W-1:0] nbr_data,
    output logic              emb_rd_en,
    output logic [NODE_W-1:0] emb_addr,
    input  logic [VEC_W-1:0]  emb_data,
    output logic              out_we,
    output logic [NODE_W-1:0] out_addr,
    output logic [VEC_W-1:0]  out_data,
    output logic              done
);

    localparam elem_t             IDENT_LANE = AGG_MAX ? ELEM_MIN : '0;
    localparam logic [VEC_W-1:0]  IDENT_VEC  = {LANES{IDENT_LANE}};

    typedef struct packed {
        eng_state_e        st;
        logic [NODE_W-1:0] node;
        logic [NODE_W-1:0] cnt;
        logic [EDGE_W-1:0] edges;
        logic [EDGE_W-1:0] pos;
        logic [EDGE_W-1:0] stop;
        logic [VEC_W-1:0]  acc;
        logic [VEC_W-1:0]  own;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    logic [VEC_W-1:0] msg_vec;
    logic [VEC_W-1:0] acc_next;
    logic [VEC_W-1:0] comb_vec;
    logic [VEC_W-1:0] upd_vec;
    logic             last_node;
    logic [EDGE_W:0]  pos_inc;

    // Message transform on the fetched neighbor embedding.
    mpn_affine #(.LANES(LANES), .SCALE(MSG_SCALE), .BIAS(MSG_BIAS)) u_msg (
        .vec_i (emb_data),
        .vec_o (msg_vec)
    );

    // Running partial aggregate.
    mpn_aggregate #(.LANES(LANES), .USE_MAX(AGG_MAX)) u_agg (
        .acc_i (r_q.acc),
        .val_i (msg_vec),
        .acc_o (acc_next)
    );

    // Combine finalized aggregate with the node's own embedding.
    mpn_aggregate #(.LANES(LANES), .USE_MAX(1'b0)) u_combine (
        .acc_i (r_q.acc),
        .val_i (r_q.own),
        .acc_o (comb_vec)
    );

    // Update transform.
    mpn_affine #(.LANES(LANES), .SCALE(UPD_SCALE), .BIAS(UPD_BIAS)) u_upd (
        .vec_i (comb_vec),
        .vec_o (upd_vec)
    );

    assign last_node = (r_q.node == r_q.cnt - NODE_W'(1));
    assign pos_inc   = {1'b0, r_q.pos} + (EDGE_W+1)'(1);

    always_comb begin
        r_d       = r_q;
        off_rd_en = 1'b0;
        off_addr  = '0;
        nbr_rd_en = 1'b0;
        nbr_addr  = '0;
        emb_rd_en = 1'b0;
        emb_addr  = '0;
        out_we    = 1'b0;
        out_addr  = '0;
        out_data  = '0;
        done      = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.cnt   = num_nodes;
                    r_d.edges = num_edges;
                    r_d.node  = '0;
                    r_d.st    = (num_nodes == '0) ? ST_DONE : ST_OFF_RD;
                end
            end
            ST_OFF_RD: begin
                off_rd_en = 1'b1;
                off_addr  = r_q.node;
                r_d.st    = ST_OFF_BEG;
            end
            ST_OFF_BEG: begin
                r_d.pos = off_data;
                if (!last_node) begin
                    off_rd_en = 1'b1;
                    off_addr  = r_q.node + NODE_W'(1);
                end
                r_d.st = ST_OFF_END;
            end
            ST_OFF_END: begin
                r_d.stop  = last_node ? r_q.edges : off_data;
                r_d.acc   = IDENT_VEC;
                emb_rd_en = 1'b1;
                emb_addr  = r_q.node;
                r_d.st    = ST_SELF;
            end
            ST_SELF: begin
                r_d.own = emb_data;
                if (r_q.pos >= r_q.stop) begin
                    r_d.st = ST_FINAL;
                end else begin
                    nbr_rd_en = 1'b1;
                    nbr_addr  = r_q.pos;
                    r_d.st    = ST_NBR;
                end
            end
            ST_NBR: begin
                emb_rd_en = 1'b1;
                emb_addr  = nbr_data;
                r_d.st    = ST_GATHER;
            end
            ST_GATHER: begin
                r_d.acc = acc_next;
                r_d.pos = pos_inc[EDGE_W-1:0];
                if (pos_inc >= {1'b0, r_q.stop}) begin
                    r_d.st = ST_FINAL;
                end else begin
                    nbr_rd_en = 1'b1;
                    nbr_addr  = pos_inc[EDGE_W-1:0];
                    r_d.st    = ST_NBR;
                end
            end
            ST_FINAL: begin
                out_we   = 1'b1;
                out_addr = r_q.node;
                out_data = upd_vec;
                if (last_node) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.node = r_q.node + NODE_W'(1);
                    r_d.st   = ST_OFF_RD;
                end
            end
            ST_DONE: begin
                done   = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R1: a node's write is never directly followed by another write.
    p_write_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |=> !out_we);

    // R1: writes stay inside the captured node range.
    p_write_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (out_addr < r_q.cnt));

    // R3: the embedding fetch after a neighbor read uses the returned index.
    p_gather_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(nbr_rd_en) |-> (emb_rd_en && emb_addr == nbr_data));

    // R9: done is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: for a non-empty graph, done follows the last write.
    p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && r_q.cnt != '0) |-> $past(out_we));

endmodule

// File: tb/sim_mpn_node_engine.sv
module sim_mpn_node_engine;

    localparam int LANES  = 4;
    localparam int NODE_W = 8;
    localparam int EDGE_W = 10;
    localparam int VEC_W  = LANES * 16;
    localparam int MS = 1536, MB = 64, US = 512, UB = -32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NODE_W-1:0] num_nodes = '0;
    logic [EDGE_W-1:0] num_edges = '0;
    logic              off_rd_en, nbr_rd_en, emb_rd_en, out_we, done;
    logic [NODE_W-1:0] off_addr, emb_addr, out_addr, nbr_data;
    logic [EDGE_W-1:0] nbr_addr, off_data;
    logic [VEC_W-1:0]  emb_data, out_data;

    logic [EDGE_W-1:0] off_mem [0:(1<<NODE_W)-1];
    logic [NODE_W-1:0] nbr_mem [0:(1<<EDGE_W)-1];
    logic [VEC_W-1:0]  emb_mem [0:(1<<NODE_W)-1];

    int checks = 0, fails = 0, cyc = 0, done_cnt = 0;
    bit prev_we = 1'b0, zero_case = 1'b0, live = 1'b0;
    int               exp_addr [$];
    logic [VEC_W-1:0] exp_data [$];

    always #4 clk = ~clk;

    mpn_node_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .num_nodes(num_nodes), .num_edges(num_edges),
        .off_rd_en(off_rd_en), .off_addr(off_addr), .off_data(off_data),
        .nbr_rd_en(nbr_rd_en), .nbr_addr(nbr_addr), .nbr_data(nbr_data),
        .emb_rd_en(emb_rd_en), .emb_addr(emb_addr), .emb_data(emb_data),
        .out_we(out_we), .out_addr(out_addr), .out_data(out_data), .done(done)
    );

    // Synchronous memories, one-cycle read latency.
    always @(posedge clk) begin
        if (off_rd_en) off_data <= off_mem[off_addr];
        if (nbr_rd_en) nbr_data <= nbr_mem[nbr_addr];
        if (emb_rd_en) emb_data <= emb_mem[emb_addr];
    end

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int aff(input int x, input int s, input int b);
        return sat16(((x * s) >>> 10) + b);
    endfunction

    task automatic check(input string req, input bit ok, input string what,
                         input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Behavioural model of one layer: R2, R3, R4, R5, R6, R7.
    task automatic build_expected(input int n, input int e);
        exp_addr.delete();
        exp_data.delete();
        for (int v = 0; v < n; v++) begin
            int beg, fin;
            int acc [LANES];
            logic [VEC_W-1:0] w;
            beg = off_mem[v];
            fin = (v == n - 1) ? e : int'(off_mem[v+1]);
            for (int l = 0; l < LANES; l++) acc[l] = 0;
            for (int p = beg; p < fin; p++) begin
                int j;
                j = nbr_mem[p];
                for (int l = 0; l < LANES; l++)
                    acc[l] = sat16(acc[l] + aff($signed(emb_mem[j][16*l +: 16]), MS, MB));
            end
            for (int l = 0; l < LANES; l++) begin
                int c;
                c = sat16(acc[l] + $signed(emb_mem[v][16*l +: 16]));
                w[16*l +: 16] = 16'(aff(c, US, UB));
            end
            exp_addr.push_back(v);
            exp_data.push_back(w);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (live) begin
            if (out_we) begin
                if (exp_addr.size() == 0) begin
                    check("R1", 1'b0, "unexpected write", VEC_W'(out_addr), '0);
                end else begin
                    int a;
                    logic [VEC_W-1:0] d;
                    a = exp_addr.pop_front();
                    d = exp_data.pop_front();
                    check("R1", out_addr == NODE_W'(a), "write address", VEC_W'(out_addr), VEC_W'(a));
                    check("R6", out_data == d, "write data (R4 R5 R7)", out_data, d);
                end
            end
            if (done) begin
                done_cnt++;
                check("R9", exp_addr.size() == 0, "done before all writes",
                      VEC_W'(exp_addr.size()), '0);
                check("R9", prev_we || zero_case, "done not right after last write",
                      VEC_W'(prev_we), 1);
            end
        end
        prev_we = out_we;
    end

    task automatic run_graph(input int n, input int e, input bit poke);
        build_expected(n, e);
        zero_case = (n == 0);
        done_cnt  = 0;
        @(negedge clk);
        num_nodes = NODE_W'(n);
        num_edges = EDGE_W'(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            // R8: a second start and a changed size mid-run must be ignored.
            repeat (6) @(negedge clk);
            num_nodes = NODE_W'(2);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 4000 && done_cnt == 0; t++) @(negedge clk);
        repeat (40) @(negedge clk);
        check("R9", done_cnt == 1, "done pulse count", VEC_W'(done_cnt), 1);
        check(poke ? "R8" : "R1", exp_addr.size() == 0, "writes missing",
              VEC_W'(exp_addr.size()), '0);
    endtask

    task automatic fill_emb(input int seed, input int span);
        int s;
        s = seed;
        for (int j = 0; j < 16; j++)
            for (int l = 0; l < LANES; l++) begin
                s = (s * 1103515245 + 12345) & 32'h7fffffff;
                emb_mem[j][16*l +: 16] = 16'((s % (2 * span + 1)) - span);
            end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc == 150000) begin
                fails++;
                $display("FAIL watchdog expired actual=%0d expected=done", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < (1 << NODE_W); i++) begin off_mem[i] = '0; emb_mem[i] = '0; end
        for (int i = 0; i < (1 << EDGE_W); i++) nbr_mem[i] = '0;

        // R10: outputs quiet in and just after reset.
        repeat (3) @(negedge clk);
        check("R10", !(done || out_we || off_rd_en || nbr_rd_en || emb_rd_en),
              "outputs during reset", VEC_W'({done, out_we, off_rd_en, nbr_rd_en, emb_rd_en}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", !(done || out_we || off_rd_en || nbr_rd_en || emb_rd_en),
              "outputs after reset", VEC_W'({done, out_we, off_rd_en, nbr_rd_en, emb_rd_en}), '0);
        live = 1'b1;

        // Graph A: mixed degrees, nodes 1 and 4 empty (R2, R3, R7), last node bounded by edge count.
        off_mem[0] = 0; off_mem[1] = 3; off_mem[2] = 3; off_mem[3] = 5; off_mem[4] = 6; off_mem[5] = 6;
        nbr_mem[0] = 1; nbr_mem[1] = 2; nbr_mem[2] = 5; nbr_mem[3] = 0; nbr_mem[4] = 4;
        nbr_mem[5] = 3; nbr_mem[6] = 2; nbr_mem[7] = 0; nbr_mem[8] = 1;
        fill_emb(7, 3000);
        run_graph(6, 9, 1'b0);

        // Negative-heavy values exercise floor rounding (R4, R6).
        fill_emb(99, 200);
        run_graph(6, 9, 1'b0);

        // Saturation (R5): large same-sign embeddings, four neighbors each.
        off_mem[0] = 0; off_mem[1] = 4; off_mem[2] = 8;
        for (int p = 0; p < 12; p++) nbr_mem[p] = NODE_W'(p % 3);
        for (int l = 0; l < LANES; l++) begin
            emb_mem[0][16*l +: 16] = 16'sd30000;
            emb_mem[1][16*l +: 16] = 16'sd29000;
            emb_mem[2][16*l +: 16] = -16'sd31000;
        end
        run_graph(3, 12, 1'b0);

        // Single node whose range ends at num_edges (R2).
        off_mem[0] = 1; nbr_mem[1] = 0; nbr_mem[2] = 0;
        fill_emb(5, 1500);
        run_graph(1, 3, 1'b0);

        // Empty graph: done only, no write (R9).
        run_graph(0, 0, 1'b0);

        // Restart attempt during a run (R8).
        off_mem[0] = 0; off_mem[1] = 3; off_mem[2] = 3; off_mem[3] = 5; off_mem[4] = 6; off_mem[5] = 6;
        nbr_mem[0] = 1; nbr_mem[1] = 2; nbr_mem[2] = 5; nbr_mem[3] = 0; nbr_mem[4] = 4;
        nbr_mem[5] = 3; nbr_mem[6] = 2; nbr_mem[7] = 0; nbr_mem[8] = 1;
        fill_emb(321, 8000);
        run_graph(6, 9, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule